// File: doc/BRIEF.md
# Codec Power Sequencing Controller

This block sits on the host side of an audio codec. It brings the codec's DAC and headphone amplifier up and down in a fixed order, and it keeps a minimum wait between steps. It drives the codec's active-low reset line and a separate enable for each of these: the reference, the PLL, the DAC, the master-clock output, the left and right DAC-to-headphone paths, the left and right headphone amplifiers, and unmute. All waits are counted in system-clock cycles. Each cycle count is a parameter, and by default it is computed from the clock frequency.

Power-good, the up and down requests, PLL-locked and headphone-output-low are asynchronous level inputs. Each one goes through a synchronizer of `SYNC_STAGES` flops, so any input change reaches the state register `SYNC_STAGES + 1` rising edges after it is applied. Power-up steps from reset release to the reference/PLL/DAC/clock group, then to the paths, then to the amplifiers with unmute. Power-down removes unmute first. It then holds the amplifiers until the headphone output is reported low, and only after that clears the paths and the rest. A down request that arrives partway through power-up abandons the power-up and returns to standby. Losing power-good drops everything at once.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset, every enable, `codec_rstn`, `busy` and `done` are low, and `seq_state` reads 8'h01 (no power).
- R2: `codec_rstn` rises exactly `SYNC_STAGES + 1 + RST_CYC` rising edges after `pwr_good` is raised, and never sooner.
- R3: In standby, an up request raises `ref_en`, `pll_en`, `dac_en` and `mclk_out_en` together, `SYNC_STAGES + 1` edges after the request. These enables are never high while `codec_rstn` is low.
- R4: Both path enables rise together, `SYNC_STAGES + 1` edges after `pll_locked` is raised, provided that is earlier than the timeout. They are never raised before the core group is on.
- R5: With no lock indication, the path enables rise exactly `LOCK_CYC` edges after the core group rises.
- R6: Both amplifier enables and `unmute` rise exactly `HP_CYC` edges after the path enables rise.
- R7: In the fully-on state, a down request drops `unmute` `SYNC_STAGES + 1` edges later while the amplifiers stay on. The amplifiers stay on for as long as `hp_out_low` is low, and they fall `SYNC_STAGES + 1` edges after it rises.
- R8: The path enables and the core group fall one edge after the amplifier enables fall. The block then sits in standby (8'h04).
- R9: A down request while waiting for lock (8'h08) or during the path wait (8'h10) clears every enable `SYNC_STAGES + 1` edges later and returns to standby. Enables not yet raised stay low.
- R10: `seq_state` is one-hot: 01 no power, 02 reset wait, 04 standby, 08 lock wait, 10 path wait, 20 on, 40 muting, 80 amplifier off. `busy` is high in 02, 08, 10, 40 and 80. `done` is high only in 20.
- R11: In standby, a down request takes priority over a simultaneous up request, so nothing is enabled.
- R12: A drop of `pwr_good` in any state lowers `codec_rstn` and every enable `SYNC_STAGES + 1` edges later, and returns to 8'h01. A drop during the reset wait means `codec_rstn` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies valid (async level) |
| up_req | input | 1 | Power-up request (async level) |
| down_req | input | 1 | Power-down request (async level) |
| pll_locked | input | 1 | Codec PLL lock indication (async level) |
| hp_out_low | input | 1 | Headphone outputs have reached ground (async level) |
| codec_rstn | output | 1 | Codec reset, active low |
| ref_en | output | 1 | Reference voltage enable |
| pll_en | output | 1 | PLL enable |
| dac_en | output | 1 | DAC enable |
| mclk_out_en | output | 1 | Master-clock output enable |
| path_en_l | output | 1 | Left DAC-to-headphone switch |
| path_en_r | output | 1 | Right DAC-to-headphone switch |
| hp_amp_en_l | output | 1 | Left headphone amplifier enable |
| hp_amp_en_r | output | 1 | Right headphone amplifier enable |
| unmute | output | 1 | Headphone unmute |
| busy | output | 1 | A timed or gated step is in progress |
| done | output | 1 | Fully powered and unmuted |
| seq_state | output | 8 | One-hot sequencer state |

## Verification
The assertions assume that `pwr_good` is the only input that can take the block out of a powered state without going through the down path. They also assume that `hp_out_low` reflects the real amplifier output, so the amplifiers may fall without it only on loss of power. The stimulus honours this. It raises `hp_out_low` only after `unmute` has been seen low, and it clears that input, the lock indication and both requests again before the next sequence starts. This way no stale synchronized level leaks into the following run. Inputs are changed on falling edges only. The lock arrival time and the hold time of the muting state are swept cycle by cycle on either side of the timeout.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  localparam int NUM_ST = 8;

  // One-hot sequencer states; bit positions are visible on seq_state.
  typedef enum logic [NUM_ST-1:0] {
    ST_NOPWR  = 8'h01,
    ST_PGWAIT = 8'h02,
    ST_STBY   = 8'h04,
    ST_CORE   = 8'h08,
    ST_PATH   = 8'h10,
    ST_ON     = 8'h20,
    ST_MUTE   = 8'h40,
    ST_HPOFF  = 8'h80
  } seq_st_e;

  // Index of each asynchronous input in the synchronizer bus.
  localparam int IN_PG   = 0;
  localparam int IN_UP   = 1;
  localparam int IN_DN   = 2;
  localparam int IN_LOCK = 3;
  localparam int IN_HPL  = 4;
  localparam int NUM_IN  = 5;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/cps_wait_timer.sv
module cps_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import codec_pwr_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int RST_CYC  = 4,
  parameter int LOCK_CYC = 16,
  parameter int HP_CYC   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_s,
  input  logic             up_s,
  input  logic             dn_s,
  input  logic             lock_s,
  input  logic             hpl_s,
  input  logic             tmr_exp,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output seq_st_e          st_q
);

  // A wait of N cycles loads N-1: the state is held while the count runs down to zero.
  localparam logic [TMR_W-1:0] RST_LD  = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] LOCK_LD = TMR_W'(LOCK_CYC - 1);
  localparam logic [TMR_W-1:0] HP_LD   = TMR_W'(HP_CYC - 1);

  seq_st_e st_d;

  always_comb begin
    st_d = st_q;
    if (!pg_s) begin
      st_d = ST_NOPWR;
    end else begin
      case (st_q)
        ST_NOPWR:  st_d = ST_PGWAIT;
        ST_PGWAIT: if (tmr_exp) st_d = ST_STBY;
        ST_STBY:   if (!dn_s && up_s) st_d = ST_CORE;
        ST_CORE: begin
          if (dn_s)                   st_d = ST_STBY;
          else if (lock_s || tmr_exp) st_d = ST_PATH;
        end
        ST_PATH: begin
          if (dn_s)         st_d = ST_STBY;
          else if (tmr_exp) st_d = ST_ON;
        end
        ST_ON:     if (dn_s) st_d = ST_MUTE;
        ST_MUTE:   if (hpl_s) st_d = ST_HPOFF;
        ST_HPOFF:  st_d = ST_STBY;
        default:   st_d = ST_NOPWR;
      endcase
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_d != st_q) begin
      case (st_d)
        ST_PGWAIT: begin tmr_load = 1'b1; tmr_val = RST_LD;  end
        ST_CORE:   begin tmr_load = 1'b1; tmr_val = LOCK_LD; end
        ST_PATH:   begin tmr_load = 1'b1; tmr_val = HP_LD;   end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_NOPWR;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/cps_out_decode.sv
module cps_out_decode
  import codec_pwr_pkg::*;
(
  input  seq_st_e st,
  output logic    rstn_o,
  output logic    core_o,
  output logic    path_o,
  output logic    amp_o,
  output logic    unmute_o,
  output logic    busy_o,
  output logic    done_o
);

  logic s_nopwr, s_pgwait, s_core, s_path, s_on, s_mute, s_hpoff;

  always_comb begin
    s_nopwr  = (st == ST_NOPWR);
    s_pgwait = (st == ST_PGWAIT);
    s_core   = (st == ST_CORE);
    s_path   = (st == ST_PATH);
    s_on     = (st == ST_ON);
    s_mute   = (st == ST_MUTE);
    s_hpoff  = (st == ST_HPOFF);

    rstn_o   = !(s_nopwr || s_pgwait);
    path_o   = s_path || s_on || s_mute || s_hpoff;
    core_o   = s_core || path_o;
    amp_o    = s_on || s_mute;
    unmute_o = s_on;
    busy_o   = s_pgwait || s_core || s_path || s_mute || s_hpoff;
    done_o   = s_on;
  end

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int RST_NS      = 150,
  parameter int LOCK_MS     = 20,
  parameter int HP_MS       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = (CLK_KHZ * RST_NS + 999999) / 1000000,
  parameter int LOCK_CYC    = CLK_KHZ * LOCK_MS,
  parameter int HP_CYC      = CLK_KHZ * HP_MS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       up_req,
  input  logic       down_req,
  input  logic       pll_locked,
  input  logic       hp_out_low,
  output logic       codec_rstn,
  output logic       ref_en,
  output logic       pll_en,
  output logic       dac_en,
  output logic       mclk_out_en,
  output logic       path_en_l,
  output logic       path_en_r,
  output logic       hp_amp_en_l,
  output logic       hp_amp_en_r,
  output logic       unmute,
  output logic       busy,
  output logic       done,
  output logic [7:0] seq_state
);

  localparam int MAX_CYC = max3(RST_CYC, LOCK_CYC, HP_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn_in;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  seq_st_e           st;
  logic              core_on, path_on, amp_on;

  always_comb begin
    raw_in          = '0;
    raw_in[IN_PG]   = pwr_good;
    raw_in[IN_UP]   = up_req;
    raw_in[IN_DN]   = down_req;
    raw_in[IN_LOCK] = pll_locked;
    raw_in[IN_HPL]  = hp_out_low;
  end

  cps_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (syn_in)
  );

  cps_wait_timer #(.W(TMR_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  cps_seq_fsm #(
    .TMR_W    (TMR_W),
    .RST_CYC  (RST_CYC),
    .LOCK_CYC (LOCK_CYC),
    .HP_CYC   (HP_CYC)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_s     (syn_in[IN_PG]),
    .up_s     (syn_in[IN_UP]),
    .dn_s     (syn_in[IN_DN]),
    .lock_s   (syn_in[IN_LOCK]),
    .hpl_s    (syn_in[IN_HPL]),
    .tmr_exp  (tmr_exp),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .st_q     (st)
  );

  cps_out_decode dec_i (
    .st       (st),
    .rstn_o   (codec_rstn),
    .core_o   (core_on),
    .path_o   (path_on),
    .amp_o    (amp_on),
    .unmute_o (unmute),
    .busy_o   (busy),
    .done_o   (done)
  );

  assign ref_en      = core_on;
  assign pll_en      = core_on;
  assign dac_en      = core_on;
  assign mclk_out_en = core_on;
  assign path_en_l   = path_on;
  assign path_en_r   = path_on;
  assign hp_amp_en_l = amp_on;
  assign hp_amp_en_r = amp_on;
  assign seq_state   = st;

endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
  parameter int RST_CYC  = 4,
  parameter int LOCK_CYC = 16,
  parameter int HP_CYC   = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       codec_rstn,
  input logic       ref_en,
  input logic       pll_en,
  input logic       dac_en,
  input logic       mclk_out_en,
  input logic       path_en_l,
  input logic       path_en_r,
  input logic       hp_amp_en_l,
  input logic       hp_amp_en_r,
  input logic       unmute,
  input logic       busy,
  input logic       done,
  input logic [7:0] seq_state
);

  logic [31:0] pg_cnt, core_cnt, path_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_cnt   <= '0;
      core_cnt <= '0;
      path_cnt <= '0;
    end else begin
      if (!pwr_good)           pg_cnt <= '0;
      else if (pg_cnt != '1)   pg_cnt <= pg_cnt + 1'b1;
      if (!(pll_en && !path_en_l)) core_cnt <= '0;
      else if (core_cnt != '1)     core_cnt <= core_cnt + 1'b1;
      if (!path_en_l)          path_cnt <= '0;
      else if (path_cnt != '1) path_cnt <= path_cnt + 1'b1;
    end
  end

  assert_rstn_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rstn) |-> (pg_cnt >= 32'(RST_CYC)));

  assert_core_needs_rstn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en || pll_en || dac_en || mclk_out_en) |-> codec_rstn);

  assert_core_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en == pll_en) && (dac_en == pll_en) && (mclk_out_en == pll_en));

  assert_path_after_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_en_l) |-> $past(pll_en));

  assert_path_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    path_en_l == path_en_r);

  assert_lock_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && !path_en_l) |-> (core_cnt < 32'(LOCK_CYC)));

  assert_amp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_amp_en_l) |-> (path_cnt >= 32'(HP_CYC)));

  assert_unmute_needs_amp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unmute |-> (hp_amp_en_l && hp_amp_en_r));

  assert_amp_needs_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_amp_en_l || hp_amp_en_r) |-> (path_en_l && path_en_r));

  assert_path_needs_dac_R8: assert property (@(posedge clk) disable iff (!rst_n)
    path_en_l |-> dac_en);

  assert_state_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(seq_state));

  assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_unmuted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> unmute);

endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(
  .RST_CYC  (RST_CYC),
  .LOCK_CYC (LOCK_CYC),
  .HP_CYC   (HP_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_good    (pwr_good),
  .codec_rstn  (codec_rstn),
  .ref_en      (ref_en),
  .pll_en      (pll_en),
  .dac_en      (dac_en),
  .mclk_out_en (mclk_out_en),
  .path_en_l   (path_en_l),
  .path_en_r   (path_en_r),
  .hp_amp_en_l (hp_amp_en_l),
  .hp_amp_en_r (hp_amp_en_r),
  .unmute      (unmute),
  .busy        (busy),
  .done        (done),
  .seq_state   (seq_state)
);

// File: tb/codec_pwr_seq_tb_top.sv
module codec_pwr_seq_tb_top;

  localparam int SYNC = 2;
  localparam int RST  = 5;
  localparam int LOCK = 40;
  localparam int HP   = 12;
  localparam int LAT  = SYNC + 1;

  localparam int I_RSTN = 0;
  localparam int I_REF  = 1;
  localparam int I_PLL  = 2;
  localparam int I_DAC  = 3;
  localparam int I_MCLK = 4;
  localparam int I_PL   = 5;
  localparam int I_PR   = 6;
  localparam int I_HL   = 7;
  localparam int I_HR   = 8;
  localparam int I_UM   = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_good, up_req, down_req, pll_locked, hp_out_low;
  logic codec_rstn, ref_en, pll_en, dac_en, mclk_out_en;
  logic path_en_l, path_en_r, hp_amp_en_l, hp_amp_en_r, unmute;
  logic busy, done;
  logic [7:0] seq_state;

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  int rise_at[10];
  int fall_at[10];
  logic [9:0] prev_v = '0;
  logic [9:0] mon_v;

  always #4 clk = ~clk;

  codec_pwr_seq #(
    .SYNC_STAGES (SYNC),
    .RST_CYC     (RST),
    .LOCK_CYC    (LOCK),
    .HP_CYC      (HP)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .up_req      (up_req),
    .down_req    (down_req),
    .pll_locked  (pll_locked),
    .hp_out_low  (hp_out_low),
    .codec_rstn  (codec_rstn),
    .ref_en      (ref_en),
    .pll_en      (pll_en),
    .dac_en      (dac_en),
    .mclk_out_en (mclk_out_en),
    .path_en_l   (path_en_l),
    .path_en_r   (path_en_r),
    .hp_amp_en_l (hp_amp_en_l),
    .hp_amp_en_r (hp_amp_en_r),
    .unmute      (unmute),
    .busy        (busy),
    .done        (done),
    .seq_state   (seq_state)
  );

  function automatic logic [9:0] outv();
    return {unmute, hp_amp_en_r, hp_amp_en_l, path_en_r, path_en_l,
            mclk_out_en, dac_en, pll_en, ref_en, codec_rstn};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Edge monitor: records the index of the rising clock edge at which each output changed.
  always @(posedge clk) begin
    #1;
    mon_v = outv();
    for (int i = 0; i < 10; i++) begin
      if (mon_v[i] && !prev_v[i]) rise_at[i] = cyc;
      if (!mon_v[i] && prev_v[i]) fall_at[i] = cyc;
    end
    prev_v = mon_v;
  end

  task automatic chk_eq(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wait_bit(input int idx, input logic val, input string req);
    logic [9:0] v;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      v = outv();
    end while (v[idx] !== val && n < 600);
    if (n >= 600) chk_eq({req, " wait"}, int'(v[idx]), int'(val));
  endtask

  task automatic wait_state(input logic [7:0] s, input string req);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (seq_state !== s && n < 600);
    if (n >= 600) chk_eq({req, " state wait"}, int'(seq_state), int'(s));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t, c, exp_p, d, q, a, j, keep;
    string tag;
    for (int i = 0; i < 10; i++) begin
      rise_at[i] = -1;
      fall_at[i] = -1;
    end
    rst_n = 1'b0;
    pwr_good = 1'b0; up_req = 1'b0; down_req = 1'b0;
    pll_locked = 1'b0; hp_out_low = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_eq("R1 outputs", int'(outv()), 0);
    chk_eq("R1 state", int'(seq_state), 8'h01);
    chk_eq("R1 busy", int'(busy), 0);
    chk_eq("R1 done", int'(done), 0);

    // R12 power-good lost during the reset wait
    pwr_good = 1'b1;
    idle(2);
    pwr_good = 1'b0;
    idle(14);
    chk_eq("R12 rstn held", int'(codec_rstn), 0);
    chk_eq("R12 state", int'(seq_state), 8'h01);

    // R2 reset release
    pwr_good = 1'b1;
    t = cyc;
    idle(LAT + 1);
    chk_eq("R10 busy in reset wait", int'(busy), 1);
    chk_eq("R10 state reset wait", int'(seq_state), 8'h02);
    wait_bit(I_RSTN, 1'b1, "R2");
    chk_eq("R2 release edge", rise_at[I_RSTN], t + LAT + RST);
    chk_eq("R10 standby", int'(seq_state), 8'h04);
    chk_eq("R10 standby busy", int'(busy), 0);

    // Sweep of lock arrival (R3..R8)
    for (int k = 0; k <= LOCK + 2; k++) begin
      up_req = 1'b1;
      t = cyc;
      wait_bit(I_PLL, 1'b1, "R3");
      up_req = 1'b0;
      c = cyc;
      chk_eq("R3 core rise", rise_at[I_PLL], t + LAT);
      chk_eq("R3 ref with pll", rise_at[I_REF], rise_at[I_PLL]);
      chk_eq("R3 dac with pll", rise_at[I_DAC], rise_at[I_PLL]);
      chk_eq("R3 mclk with pll", rise_at[I_MCLK], rise_at[I_PLL]);
      chk_eq("R10 lock wait state", int'(seq_state), 8'h08);
      chk_eq("R10 lock wait busy", int'(busy), 1);
      idle(k);
      if (k < LOCK) pll_locked = 1'b1;
      exp_p = (k < LOCK && k + LAT < LOCK) ? c + k + LAT : c + LOCK;
      tag = (k < LOCK && k + LAT < LOCK) ? "R4" : "R5";
      wait_bit(I_UM, 1'b1, "R6");
      chk_eq({tag, " path rise"}, rise_at[I_PL], exp_p);
      chk_eq("R4 right path", rise_at[I_PR], rise_at[I_PL]);
      chk_eq("R6 amp gap", rise_at[I_HL], rise_at[I_PL] + HP);
      chk_eq("R6 right amp", rise_at[I_HR], rise_at[I_PL] + HP);
      chk_eq("R6 unmute", rise_at[I_UM], rise_at[I_PL] + HP);
      chk_eq("R10 on state", int'(seq_state), 8'h20);
      chk_eq("R10 done", int'(done), 1);
      pll_locked = 1'b0;

      // Power-down with a swept hold before the output reports low
      j = k % 5;
      down_req = 1'b1;
      d = cyc;
      wait_bit(I_UM, 1'b0, "R7");
      chk_eq("R7 unmute fall", fall_at[I_UM], d + LAT);
      idle(j);
      chk_eq("R7 amp held", int'(hp_amp_en_l && hp_amp_en_r), 1);
      chk_eq("R7 muting state", int'(seq_state), 8'h40);
      hp_out_low = 1'b1;
      q = cyc;
      wait_state(8'h04, "R8");
      chk_eq("R7 amp fall", fall_at[I_HL], q + LAT);
      chk_eq("R7 right amp fall", fall_at[I_HR], q + LAT);
      chk_eq("R8 path fall", fall_at[I_PL], q + LAT + 1);
      chk_eq("R8 core fall", fall_at[I_PLL], q + LAT + 1);
      down_req = 1'b0;
      hp_out_low = 1'b0;
      idle(4);
    end

    // R9 abort while waiting for lock
    keep = rise_at[I_PL];
    up_req = 1'b1;
    wait_bit(I_PLL, 1'b1, "R9");
    up_req = 1'b0;
    idle(2);
    down_req = 1'b1;
    a = cyc;
    idle(LAT + 3);
    chk_eq("R9 core abort", fall_at[I_PLL], a + LAT);
    chk_eq("R9 path never", rise_at[I_PL], keep);
    chk_eq("R9 standby", int'(seq_state), 8'h04);
    down_req = 1'b0;
    idle(4);

    // R9 abort during the path wait
    keep = rise_at[I_HL];
    up_req = 1'b1;
    pll_locked = 1'b1;
    wait_bit(I_PL, 1'b1, "R9");
    up_req = 1'b0;
    pll_locked = 1'b0;
    idle(2);
    down_req = 1'b1;
    a = cyc;
    idle(LAT + 3);
    chk_eq("R9 path abort", fall_at[I_PL], a + LAT);
    chk_eq("R9 core abort", fall_at[I_PLL], a + LAT);
    chk_eq("R9 amp never", rise_at[I_HL], keep);
    chk_eq("R9 outputs", int'(outv()), 1);
    down_req = 1'b0;
    idle(4);

    // R11 down wins over up in standby
    up_req = 1'b1;
    down_req = 1'b1;
    idle(12);
    chk_eq("R11 pll off", int'(pll_en), 0);
    chk_eq("R11 state", int'(seq_state), 8'h04);
    up_req = 1'b0;
    down_req = 1'b0;
    idle(4);
    chk_eq("R11 still standby", int'(seq_state), 8'h04);

    // R12 power-good lost while fully on
    up_req = 1'b1;
    pll_locked = 1'b1;
    wait_bit(I_UM, 1'b1, "R12");
    up_req = 1'b0;
    pll_locked = 1'b0;
    idle(2);
    pwr_good = 1'b0;
    a = cyc;
    idle(LAT + 3);
    chk_eq("R12 rstn fall", fall_at[I_RSTN], a + LAT);
    chk_eq("R12 unmute fall", fall_at[I_UM], a + LAT);
    chk_eq("R12 amp fall", fall_at[I_HL], a + LAT);
    chk_eq("R12 outputs", int'(outv()), 0);
    chk_eq("R12 state", int'(seq_state), 8'h01);
    chk_eq("R12 status", int'({busy, done}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule